// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into CAN bit timing. A prescaler divides the clock into time quanta. A segment sequencer then steps each bit through four segments in turn: sync, propagation, phase 1 and phase 2. It emits two one-clock strobes. The transmit strobe marks the start of each bit. The sample strobe marks the point where the receiver should latch the bus level.

A protocol controller drives two inputs. `rx_edge` pulses on each recessive-to-dominant transition seen on the receive line. `hard_sync` pulses when the controller wants the bit clock restarted, for example at start of frame. A receive edge that falls outside the sync segment moves the sample point, but never by more than the configured jump width. This keeps the local bit clock aligned to the transmitter.

The block checks the configuration fields continuously. When they describe a bit that is too short or too long, it raises an error flag and holds the timing idle.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `qdiv`+1 clocks. With no edges and no hard sync, the distance between two consecutive `tx_pt` pulses is (`qdiv`+1)·(`prop_len`+`ph1_len`+`ph2_len`+4) clocks.
- R2: `tx_pt` is high for exactly the first clock of the sync segment of every bit and low otherwise. `tx_pt` and `sample_pt` are never high together.
- R3: `sample_pt` is high for exactly one clock, the last clock of phase 1. Without resynchronisation, this is (`qdiv`+1)·(`prop_len`+`ph1_len`+3)−1 clocks after `tx_pt`.
- R4: A receive edge during the propagation segment or phase 1 lengthens phase 1 by min(e, `jump`+1) quanta. Here e counts the quanta from the end of sync up to and including the quantum in which the edge arrives.
- R5: A receive edge during phase 2 shortens phase 2 by min(r, `jump`+1) quanta. Here r is the number of whole phase-2 quanta left after the quantum holding the edge. The bit therefore ends at the close of that quantum at the earliest.
- R6: A receive edge during the sync segment has no effect. Only the first edge after a sample point may resynchronise. Further edges are ignored until the next `sample_pt`.
- R7: When `hard_sync` is high in a clock, the next clock is the first clock of a new bit with `tx_pt` high. The quantum prescaler restarts, and `hard_sync` wins over `rx_edge` in the same clock.
- R8: `cfg_err` is high whenever the total 1+(`prop_len`+1)+(`ph1_len`+1)+(`ph2_len`+1) lies outside 8 to 25 quanta. While it is high, no strobe is produced and the bit is held at the start of sync. Once the configuration becomes valid, `tx_pt` is high in the first clock.
- R9: While `rst_n` is low, both strobes are low. With a valid configuration, `tx_pt` is high in the first clock after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qdiv | input | 6 | Quantum prescaler value, quantum = qdiv+1 clocks |
| prop_len | input | 3 | Propagation segment length minus one, in quanta |
| ph1_len | input | 3 | Phase 1 length minus one, in quanta |
| ph2_len | input | 3 | Phase 2 length minus one, in quanta |
| jump | input | 2 | Synchronisation jump width minus one, in quanta |
| rx_edge | input | 1 | One-clock pulse on a recessive-to-dominant receive edge |
| hard_sync | input | 1 | Restart the bit at the sync segment |
| tx_pt | output | 1 | Transmission point strobe, first clock of each bit |
| sample_pt | output | 1 | Sample point strobe, last clock of phase 1 |
| cfg_err | output | 1 | Configuration gives a bit length outside 8..25 quanta |

## Verification
Faults in the segment counter, the prescaler or the end-index arithmetic change the spacing between `tx_pt` and `sample_pt`. That change is visible within the first bit after the fault. Each strobe offset is measured in clocks against lengths computed by hand for each configuration.

A wrong resynchronisation state shows up differently. A stale extension, cut or sync flag only moves the strobes of the bit in which the edge arrives, or of the next one. For that reason, every edge test measures that same bit and sets its edges so that each cap and each ignore rule gives a different clock count.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
// Shared types for the CAN bit timing generator.
package cbt_pkg;
    // Segment order is behaviour: the sequencer walks them in this order.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;
endpackage

// File: rtl/cbt_prescaler.sv
`timescale 1ns/1ps
// Time-quantum prescaler.
// Produces tq_tick on the last clock of every quantum (qdiv+1 clocks long)
// and tq_first on its first clock. Assumes qdiv is stable while running.
// Held at zero while not running or while restart is high.
module cbt_prescaler #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] qdiv,
    output logic             tq_tick,
    output logic             tq_first
);
    logic [DIV_W-1:0] cnt_q;

    // Count clocks inside the current quantum.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt_q <= '0;
        end else if (cnt_q >= qdiv) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Quantum boundary strobes.
    always_comb begin
        tq_tick  = run && !restart && (cnt_q >= qdiv);
        tq_first = run && (cnt_q == '0);
    end
endmodule

// File: rtl/cbt_cfg_check.sv
`timescale 1ns/1ps
// Configuration range check.
// Total bit length in quanta = sync(1) + three segments of (field+1).
// Flags the configuration as usable only inside [TQ_MIN, TQ_MAX].
module cbt_cfg_check #(
    parameter int SEG_W  = 3,
    parameter int TQ_MIN = 8,
    parameter int TQ_MAX = 25
) (
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    output logic             cfg_ok
);
    localparam int SUM_W = SEG_W + 3;
    logic [SUM_W-1:0] total;

    // Sum the nominal bit length and compare to the legal window.
    always_comb begin
        total  = SUM_W'(prop_len) + SUM_W'(ph1_len) + SUM_W'(ph2_len) + SUM_W'(4);
        cfg_ok = (total >= SUM_W'(TQ_MIN)) && (total <= SUM_W'(TQ_MAX));
    end
endmodule

// File: rtl/cbt_seg_seq.sv
`timescale 1ns/1ps
// Bit segment sequencer with resynchronisation.
// Walks sync -> prop -> phase1 -> phase2 per quantum tick. A receive edge in
// prop/phase1 stretches phase1, one in phase2 trims phase2, both capped by
// the jump width; one resync is allowed between sample points.
// Assumes segment fields are stable within a bit and quanta come from
// cbt_prescaler.
module cbt_seg_seq
    import cbt_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hard_sync,
    input  logic             rx_edge,
    input  logic             tq_tick,
    input  logic             tq_first,
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] jump,
    output logic             tx_pt,
    output logic             sample_pt
);
    localparam int QC_W  = SEG_W + 2;
    localparam int JW    = SJW_W + 1;
    localparam int ERR_W = QC_W + 1;

    seg_e            seg_q;
    logic [QC_W-1:0] qc_q;
    logic [JW-1:0]   ext_q, cut_q;
    logic            synced_q;

    logic [JW-1:0]    jw_tq, ext_new, cut_new, ext_cur, cut_cur;
    logic [ERR_W-1:0] err_late;
    logic [QC_W-1:0]  rem, end_idx;
    logic             edge_ok, edge_early, edge_late, seg_done;

    // Phase error and capped correction for an accepted edge.
    always_comb begin
        jw_tq      = JW'(jump) + JW'(1);
        edge_ok    = run && rx_edge && !hard_sync && !synced_q && (seg_q != SEG_SYNC);
        edge_late  = edge_ok && ((seg_q == SEG_PROP) || (seg_q == SEG_PH1));
        edge_early = edge_ok && (seg_q == SEG_PH2);
        if (seg_q == SEG_PROP)
            err_late = ERR_W'(qc_q) + ERR_W'(1);
        else
            err_late = ERR_W'(prop_len) + ERR_W'(qc_q) + ERR_W'(2);
        ext_new = (err_late > ERR_W'(jw_tq)) ? jw_tq : JW'(err_late);
        rem     = (QC_W'(ph2_len) > qc_q) ? (QC_W'(ph2_len) - qc_q) : '0;
        cut_new = (rem > QC_W'(jw_tq)) ? jw_tq : JW'(rem);
        ext_cur = edge_late  ? ext_new : ext_q;
        cut_cur = edge_early ? cut_new : cut_q;
    end

    // Last quantum index of the current segment and the strobes.
    always_comb begin
        case (seg_q)
            SEG_SYNC: end_idx = '0;
            SEG_PROP: end_idx = QC_W'(prop_len);
            SEG_PH1:  end_idx = QC_W'(ph1_len) + QC_W'(ext_cur);
            default:  end_idx = QC_W'(ph2_len) - QC_W'(cut_cur);
        endcase
        seg_done  = tq_tick && (qc_q >= end_idx);
        sample_pt = seg_done && (seg_q == SEG_PH1);
        tx_pt     = run && (seg_q == SEG_SYNC) && tq_first;
    end

    // Segment state, quantum count and resync bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || hard_sync) begin
            seg_q    <= SEG_SYNC;
            qc_q     <= '0;
            ext_q    <= '0;
            cut_q    <= '0;
            synced_q <= 1'b0;
        end else begin
            if (edge_ok)    synced_q <= 1'b1;
            if (edge_late)  ext_q    <= ext_new;
            if (edge_early) cut_q    <= cut_new;
            if (seg_done) begin
                qc_q <= '0;
                case (seg_q)
                    SEG_SYNC: seg_q <= SEG_PROP;
                    SEG_PROP: seg_q <= SEG_PH1;
                    SEG_PH1: begin
                        seg_q    <= SEG_PH2;
                        synced_q <= 1'b0;
                    end
                    default: begin
                        seg_q <= SEG_SYNC;
                        ext_q <= '0;
                        cut_q <= '0;
                    end
                endcase
            end else if (tq_tick) begin
                qc_q <= qc_q + QC_W'(1);
            end
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
// CAN bit timing generator top.
// Ties the configuration check, the quantum prescaler and the segment
// sequencer together. Assumes rx_edge is already a one-clock edge pulse
// synchronised to clk.
module can_bit_timer #(
    parameter int DIV_W  = 6,
    parameter int SEG_W  = 3,
    parameter int SJW_W  = 2,
    parameter int TQ_MIN = 8,
    parameter int TQ_MAX = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] qdiv,
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] jump,
    input  logic             rx_edge,
    input  logic             hard_sync,
    output logic             tx_pt,
    output logic             sample_pt,
    output logic             cfg_err
);
    logic cfg_ok, run, tq_tick, tq_first;

    // Run only out of reset and with a legal configuration.
    always_comb begin
        run     = cfg_ok && rst_n;
        cfg_err = !cfg_ok;
    end

    cbt_cfg_check #(.SEG_W(SEG_W), .TQ_MIN(TQ_MIN), .TQ_MAX(TQ_MAX)) cfg_i (
        .prop_len (prop_len),
        .ph1_len  (ph1_len),
        .ph2_len  (ph2_len),
        .cfg_ok   (cfg_ok)
    );

    cbt_prescaler #(.DIV_W(DIV_W)) pre_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (hard_sync),
        .qdiv     (qdiv),
        .tq_tick  (tq_tick),
        .tq_first (tq_first)
    );

    cbt_seg_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hard_sync (hard_sync),
        .rx_edge   (rx_edge),
        .tq_tick   (tq_tick),
        .tq_first  (tq_first),
        .prop_len  (prop_len),
        .ph1_len   (ph1_len),
        .ph2_len   (ph2_len),
        .jump      (jump),
        .tx_pt     (tx_pt),
        .sample_pt (sample_pt)
    );
endmodule

// File: rtl/cbt_checker.sv
`timescale 1ns/1ps
// Port-level properties of the bit timing generator, bound to the top.
module cbt_checker (
    input logic clk,
    input logic rst_n,
    input logic hard_sync,
    input logic tx_pt,
    input logic sample_pt,
    input logic cfg_err
);
    // R2: the two strobes never coincide.
    a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pt && sample_pt));

    // R2: a transmit strobe lasts one clock unless a hard sync restarts the bit.
    a_r2_tx_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pt && !hard_sync) |=> !tx_pt);

    // R3: a sample strobe lasts one clock.
    a_r3_sample_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |=> !sample_pt);

    // R7: a hard sync starts a new bit in the next clock.
    a_r7_hard_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        hard_sync |=> (tx_pt || cfg_err));

    // R8: no strobe while the configuration is illegal.
    a_r8_idle_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!tx_pt && !sample_pt));

    // R9: strobes stay low during reset.
    always_comb begin
        if (!rst_n) a_r9_quiet_in_reset: assert (!tx_pt && !sample_pt);
    end
endmodule

bind can_bit_timer cbt_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hard_sync (hard_sync),
    .tx_pt     (tx_pt),
    .sample_pt (sample_pt),
    .cfg_err   (cfg_err)
);

// File: tb/can_bit_timer_tb_top.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] qdiv = '0;
    logic [2:0] prop_len = '0, ph1_len = '0, ph2_len = '0;
    logic [1:0] jump = '0;
    logic       rx_edge = 1'b0, hard_sync = 1'b0;
    logic       tx_pt, sample_pt, cfg_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .qdiv(qdiv), .prop_len(prop_len),
        .ph1_len(ph1_len), .ph2_len(ph2_len), .jump(jump),
        .rx_edge(rx_edge), .hard_sync(hard_sync),
        .tx_pt(tx_pt), .sample_pt(sample_pt), .cfg_err(cfg_err)
    );

    // qdiv, prop, ph1, ph2, expected bit clocks, expected sample offset
    localparam int VEC [6][6] = '{
        '{ 0, 2, 1, 1,   8,   5},
        '{ 1, 1, 2, 2,  18,  11},
        '{ 0, 7, 7, 7,  25,  16},
        '{ 3, 0, 3, 2,  36,  23},
        '{ 5, 4, 0, 3,  66,  41},
        '{63, 2, 1, 1, 512, 383}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Measure one bit from a tx strobe; inject edges/hard sync at offsets.
    task automatic run_bit(input int e1, input int e2, input int hs,
                           output int soff, output int blen);
        int guard = 0;
        while (!tx_pt && guard < 3000) begin step(); guard++; end
        soff = -1;
        blen = -1;
        rx_edge   = (e1 == 0) || (e2 == 0);
        hard_sync = (hs == 0);
        for (int t = 1; t < 3000; t++) begin
            step();
            if (sample_pt && soff < 0) soff = t;
            if (tx_pt) begin
                blen = t;
                rx_edge = 1'b0;
                hard_sync = 1'b0;
                break;
            end
            rx_edge   = (t == e1) || (t == e2);
            hard_sync = (t == hs);
        end
    endtask

    task automatic set_cfg(input int d, input int p, input int a, input int b, input int j);
        qdiv = 6'(d); prop_len = 3'(p); ph1_len = 3'(a); ph2_len = 3'(b); jump = 2'(j);
    endtask

    task automatic restart();
        hard_sync = 1'b1;
        step();
        hard_sync = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int so, bl, cnt;
        // R9: reset quiet, tx in first clock after release
        set_cfg(1, 1, 2, 2, 1);
        repeat (4) step();
        chk("R9 tx in reset", int'(tx_pt), 0);
        chk("R9 sample in reset", int'(sample_pt), 0);
        rst_n = 1'b1;
        #1;
        chk("R9 tx first clock", int'(tx_pt), 1);

        // R1/R3: vector table
        for (int i = 0; i < 6; i++) begin
            step();
            set_cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1);
            restart();
            chk("R8 legal cfg flag", int'(cfg_err), 0);
            run_bit(-1, -1, -1, so, bl);
            chk("R3 sample offset", so, VEC[i][5]);
            chk("R1 bit length", bl, VEC[i][4]);
        end

        // Directed resync tests on 2-clock quanta, 9-quantum bit
        step(); set_cfg(1, 1, 2, 2, 1); restart();
        run_bit(6, -1, -1, so, bl);
        chk("R4 ph1 capped sample", so, 15); chk("R4 ph1 capped bit", bl, 22);
        set_cfg(1, 1, 2, 2, 3);
        run_bit(6, -1, -1, so, bl);
        chk("R4 ph1 uncapped sample", so, 17); chk("R4 ph1 uncapped bit", bl, 24);
        run_bit(10, -1, -1, so, bl);
        chk("R4 ph1 cap4 sample", so, 19); chk("R4 ph1 cap4 bit", bl, 26);
        set_cfg(1, 1, 2, 2, 1);
        run_bit(2, -1, -1, so, bl);
        chk("R4 prop edge sample", so, 13); chk("R4 prop edge bit", bl, 20);
        run_bit(12, -1, -1, so, bl);
        chk("R5 ph2 sample", so, 11); chk("R5 ph2 cut2 bit", bl, 14);
        set_cfg(1, 1, 2, 2, 0);
        run_bit(12, -1, -1, so, bl);
        chk("R5 ph2 cut1 bit", bl, 16);
        set_cfg(1, 1, 2, 2, 1);
        run_bit(16, -1, -1, so, bl);
        chk("R5 last quantum bit", bl, 18);
        run_bit(0, -1, -1, so, bl);
        chk("R6 sync edge sample", so, 11); chk("R6 sync edge bit", bl, 18);
        run_bit(2, 8, -1, so, bl);
        chk("R6 second edge sample", so, 13); chk("R6 second edge bit", bl, 20);
        run_bit(2, 14, -1, so, bl);
        chk("R6 rearm sample", so, 13); chk("R6 rearm bit", bl, 16);

        // R7: hard sync mid-bit
        run_bit(5, -1, 5, so, bl);
        chk("R7 hard sync bit", bl, 6); chk("R7 no sample", so, -1);
        run_bit(-1, -1, -1, so, bl);
        chk("R7 next bit", bl, 18);

        // R8: illegal config (7 quanta) holds idle
        set_cfg(1, 1, 1, 1, 1);
        #1;
        chk("R8 error flag", int'(cfg_err), 1);
        cnt = 0;
        for (int k = 0; k < 60; k++) begin
            step();
            if (tx_pt || sample_pt) cnt++;
        end
        chk("R8 no strobes", cnt, 0);
        set_cfg(1, 1, 2, 2, 1);
        #1;
        chk("R8 restart tx", int'(tx_pt), 1);
        run_bit(-1, -1, -1, so, bl);
        chk("R8 bit after recovery", bl, 18);

        finish_run();
    end
endmodule